// File: doc/BRIEF.md
# Partial Register Merge Tracker

This block keeps a small architectural register file in which each 64-bit register can hold separately tracked narrow pieces: a low byte, a high byte (bits 15:8) and a low word. Each accepted instruction reads one register at a chosen width and then writes one register at a chosen width. When a read needs more bits than the narrow pieces waiting on that register can supply, the block folds the pieces into the full value. It charges a stall and, in one mode, requests a merge micro-op.

Three handling policies are available, and one is fixed at reset. The stalling policy holds the read for a fixed 5 or 6 cycles. The merge-op policy inserts a merge at no cost for low pieces and costs extra cycles for a high-byte piece. The direct policy merges every narrow write into the full register as it happens, so no read ever waits. A downstream model uses the stall and merge outputs to account for the cost of wide reads that follow narrow writes.

Top module: `preg_merge_top`

## Requirements
- R1: After reset every register reads as zero with no narrow piece waiting. While idle, `in_ready_o`=1, `rd_valid_o`=0, `stall_o`=0 and `merge_req_o`=0.
- R2: Width codes on `dst_w_i`/`src_w_i` are 0 = low byte, 1 = high byte (bits 15:8), 2 = low word, 3 = 32-bit and 4 = 64-bit. A read returns the selected bits zero-extended into bit 0 upward: code 1 returns bits 15:8 in result bits 7:0.
- R3: An instruction reads its source before its own write takes effect. Byte and word writes leave all other bits of the register unchanged for later reads.
- R4: A 32-bit write stores zero in bits 63:32. A 32-bit or 64-bit write drops every narrow piece waiting on that register, so a following wide read needs no merge.
- R5: A merge is needed when a word read meets a waiting byte piece, or when a 32-bit or 64-bit read meets any waiting piece. Byte reads, and word reads over a waiting word piece alone, never need a merge.
- R6: In the stalling policy (mode 0), a read that needs a merge holds `in_ready_o` low for exactly LEGACY_STALL cycles (5 or 6) and then delivers the merged value.
- R7: In the merge-op policy (mode 1), a needed merge pulses `merge_req_o` in the cycle after acceptance. If only low pieces were waiting, it adds no stall.
- R8: In the merge-op policy, a needed merge that involves a waiting high-byte piece stalls for HI_EXTRA_STALL cycles (default 1).
- R9: In the direct policy (modes 2 and 3), narrow writes merge at once, and no read ever stalls or raises `merge_req_o`.
- R10: `mode_i` is sampled only while reset is asserted. Changing it afterwards has no effect.
- R11: Without a stall, `rd_valid_o` is high in the cycle after acceptance. Each accepted instruction yields exactly one `rd_valid_o` cycle. Inputs presented while `in_ready_o` is low are ignored.
- R12: A merge folds all waiting pieces of the source register into its full value, so repeating the same wide read needs no merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy select, sampled during reset |
| in_valid_i | input | 1 | Instruction present |
| dst_idx_i | input | IDX_W | Destination register |
| dst_w_i | input | 3 | Write width code (codes 5 to 7 act as 64-bit) |
| src_idx_i | input | IDX_W | Source register |
| src_w_i | input | 3 | Read width code |
| wr_data_i | input | 64 | Write value |
| in_ready_o | output | 1 | Instruction accepted when high together with valid |
| stall_o | output | 1 | A merge penalty is being served |
| merge_req_o | output | 1 | Merge micro-op inserted (merge-op policy) |
| rd_valid_o | output | 1 | Read result present |
| rd_data_o | output | 64 | Read result |

## Verification
The properties assume that `mode_i` is held steady for several clocks while reset is low. They also assume that an instruction is counted only on a cycle where both valid and ready are high. The stimulus drives inputs just after a rising edge and holds them through the next edge. It changes the mode only inside reset, except for one deliberate change after reset that must have no effect. It uses only width codes 0 to 4. During a stall it presents exactly one extra instruction to show that the instruction is dropped.

// File: rtl/preg_pkg.sv
package preg_pkg;

   localparam int unsigned XLEN = 64;

   typedef enum logic [2:0] {
      W_LO8 = 3'd0,
      W_HI8 = 3'd1,
      W_16  = 3'd2,
      W_32  = 3'd3,
      W_64  = 3'd4
   } width_e;

   typedef enum logic [1:0] {
      M_LEGACY    = 2'd0,
      M_MERGE_UOP = 2'd1,
      M_DIRECT    = 2'd2
   } mode_e;

   typedef struct packed {
      logic [XLEN-1:0] base;
      logic [15:0]     lo;
      logic [7:0]      hi;
      logic            lo8_p;
      logic            lo16_p;
      logic            hi8_p;
   } pstate_t;

   // Architectural value: full value overlaid with any waiting pieces.
   function automatic logic [XLEN-1:0] fold_state(pstate_t s);
      logic [XLEN-1:0] v;
      v = s.base;
      if (s.lo16_p)
         v[15:0] = s.lo;
      else if (s.lo8_p)
         v[7:0] = s.lo[7:0];
      if (s.hi8_p)
         v[15:8] = s.hi;
      return v;
   endfunction

   function automatic mode_e decode_mode(logic [1:0] m);
      mode_e r;
      case (m)
         2'd0:    r = M_LEGACY;
         2'd1:    r = M_MERGE_UOP;
         default: r = M_DIRECT;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/preg_state_file.sv
module preg_state_file
   import preg_pkg::*;
#(
   parameter int unsigned NREGS = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             direct_i,
   input  logic             fold_en_i,
   input  logic [IDX_W-1:0] fold_idx_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  width_e           wr_w_i,
   input  logic [XLEN-1:0]  wr_data_i,
   output pstate_t          st_o [NREGS]
);

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      pstate_t st_q;
      pstate_t nx;

      always_comb begin
         nx = st_q;
         // merge step for a read that needed it (happens before the write)
         if (fold_en_i && fold_idx_i == IDX_W'(g)) begin
            nx.base   = fold_state(st_q);
            nx.lo8_p  = 1'b0;
            nx.lo16_p = 1'b0;
            nx.hi8_p  = 1'b0;
         end
         if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
            if (direct_i) begin
               case (wr_w_i)
                  W_LO8: nx.base[7:0]  = wr_data_i[7:0];
                  W_HI8: nx.base[15:8] = wr_data_i[7:0];
                  W_16:  nx.base[15:0] = wr_data_i[15:0];
                  W_32: begin
                     nx.base   = {32'b0, wr_data_i[31:0]};
                     nx.lo8_p  = 1'b0;
                     nx.lo16_p = 1'b0;
                     nx.hi8_p  = 1'b0;
                  end
                  default: begin
                     nx.base   = wr_data_i;
                     nx.lo8_p  = 1'b0;
                     nx.lo16_p = 1'b0;
                     nx.hi8_p  = 1'b0;
                  end
               endcase
            end else begin
               case (wr_w_i)
                  W_LO8: begin
                     nx.lo[7:0] = wr_data_i[7:0];
                     if (!nx.lo16_p)
                        nx.lo8_p = 1'b1;
                  end
                  W_HI8: begin
                     nx.hi    = wr_data_i[7:0];
                     nx.hi8_p = 1'b1;
                  end
                  W_16: begin
                     nx.lo     = wr_data_i[15:0];
                     nx.lo16_p = 1'b1;
                     nx.lo8_p  = 1'b0;
                     nx.hi8_p  = 1'b0;
                  end
                  W_32: begin
                     nx.base   = {32'b0, wr_data_i[31:0]};
                     nx.lo8_p  = 1'b0;
                     nx.lo16_p = 1'b0;
                     nx.hi8_p  = 1'b0;
                  end
                  default: begin
                     nx.base   = wr_data_i;
                     nx.lo8_p  = 1'b0;
                     nx.lo16_p = 1'b0;
                     nx.hi8_p  = 1'b0;
                  end
               endcase
            end
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            st_q <= '0;
         else
            st_q <= nx;
      end

      assign st_o[g] = st_q;
   end

endmodule

// File: rtl/preg_merge_detect.sv
module preg_merge_detect
   import preg_pkg::*;
#(
   parameter int unsigned LEGACY_STALL   = 5,
   parameter int unsigned HI_EXTRA_STALL = 1,
   parameter int unsigned CNT_W          = 3
) (
   input  mode_e            mode_i,
   input  width_e           rd_w_i,
   input  logic             lo8_p_i,
   input  logic             lo16_p_i,
   input  logic             hi8_p_i,
   output logic             need_o,
   output logic [CNT_W-1:0] cost_o
);

   logic wide_rd;
   logic byte_piece;
   logic need_raw;

   assign wide_rd    = !(rd_w_i == W_LO8 || rd_w_i == W_HI8 || rd_w_i == W_16);
   assign byte_piece = lo8_p_i || hi8_p_i;
   assign need_raw   = ((rd_w_i == W_16) && byte_piece) ||
                       (wide_rd && (byte_piece || lo16_p_i));
   assign need_o     = need_raw && (mode_i != M_DIRECT);

   always_comb begin
      cost_o = '0;
      if (need_o) begin
         case (mode_i)
            M_LEGACY:    cost_o = CNT_W'(LEGACY_STALL);
            M_MERGE_UOP: cost_o = hi8_p_i ? CNT_W'(HI_EXTRA_STALL) : '0;
            default:     cost_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/preg_read_fmt.sv
module preg_read_fmt
   import preg_pkg::*;
(
   input  pstate_t         src_i,
   input  width_e          rd_w_i,
   output logic [XLEN-1:0] value_o
);

   logic [XLEN-1:0] arch;

   assign arch = fold_state(src_i);

   always_comb begin
      case (rd_w_i)
         W_LO8:   value_o = XLEN'(arch[7:0]);
         W_HI8:   value_o = XLEN'(arch[15:8]);
         W_16:    value_o = XLEN'(arch[15:0]);
         W_32:    value_o = XLEN'(arch[31:0]);
         default: value_o = arch;
      endcase
   end

endmodule

// File: rtl/preg_stall_ctrl.sv
module preg_stall_ctrl
   import preg_pkg::*;
#(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             accept_i,
   input  logic             need_i,
   input  logic             muop_i,
   input  logic [CNT_W-1:0] cost_i,
   input  logic [XLEN-1:0]  value_i,
   output logic             ready_o,
   output logic             stall_o,
   output logic             rd_valid_o,
   output logic [XLEN-1:0]  rd_data_o,
   output logic             merge_req_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             vld_q;
   logic             mrg_q;
   logic [XLEN-1:0]  dat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         vld_q <= 1'b0;
         mrg_q <= 1'b0;
         dat_q <= '0;
      end else begin
         mrg_q <= accept_i && need_i && muop_i;
         if (accept_i) begin
            dat_q <= value_i;
            cnt_q <= cost_i;
            vld_q <= (cost_i == '0);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
            vld_q <= (cnt_q == CNT_W'(1));
         end else begin
            vld_q <= 1'b0;
         end
      end
   end

   assign ready_o     = (cnt_q == '0);
   assign stall_o     = (cnt_q != '0);
   assign rd_valid_o  = vld_q;
   assign rd_data_o   = dat_q;
   assign merge_req_o = mrg_q;

endmodule

// File: rtl/preg_merge_top.sv
module preg_merge_top
   import preg_pkg::*;
#(
   parameter  int unsigned NREGS          = 8,
   parameter  int unsigned LEGACY_STALL   = 5,
   parameter  int unsigned HI_EXTRA_STALL = 1,
   localparam int unsigned IDX_W          = $clog2(NREGS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       mode_i,
   input  logic             in_valid_i,
   input  logic [IDX_W-1:0] dst_idx_i,
   input  logic [2:0]       dst_w_i,
   input  logic [IDX_W-1:0] src_idx_i,
   input  logic [2:0]       src_w_i,
   input  logic [63:0]      wr_data_i,
   output logic             in_ready_o,
   output logic             stall_o,
   output logic             merge_req_o,
   output logic             rd_valid_o,
   output logic [63:0]      rd_data_o
);

   localparam int unsigned MAX_COST = (LEGACY_STALL > HI_EXTRA_STALL) ?
                                      LEGACY_STALL : HI_EXTRA_STALL;
   localparam int unsigned CNT_W    = $clog2(MAX_COST + 1);

   if (LEGACY_STALL < 5 || LEGACY_STALL > 6) begin : g_bad_legacy
      $error("LEGACY_STALL must be 5 or 6");
   end
   if (HI_EXTRA_STALL < 1 || HI_EXTRA_STALL > 4) begin : g_bad_hi
      $error("HI_EXTRA_STALL must be 1 to 4");
   end
   if (NREGS < 2 || (1 << IDX_W) != NREGS) begin : g_bad_nregs
      $error("NREGS must be a power of two, at least 2");
   end
   if (XLEN != 64) begin : g_bad_xlen
      $error("register width must be 64");
   end

   mode_e            mode_q;
   width_e           wr_w;
   width_e           rd_w;
   pstate_t          st [NREGS];
   pstate_t          src_st;
   logic             accept;
   logic             need;
   logic [CNT_W-1:0] cost;
   logic [XLEN-1:0]  rd_value;

   // policy captured only while reset is held
   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         mode_q <= decode_mode(mode_i);
   end

   assign wr_w   = width_e'(dst_w_i);
   assign rd_w   = width_e'(src_w_i);
   assign src_st = st[src_idx_i];
   assign accept = in_valid_i && in_ready_o;

   preg_state_file #(
      .NREGS (NREGS),
      .IDX_W (IDX_W)
   ) u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .direct_i   (mode_q == M_DIRECT),
      .fold_en_i  (accept && need),
      .fold_idx_i (src_idx_i),
      .wr_en_i    (accept),
      .wr_idx_i   (dst_idx_i),
      .wr_w_i     (wr_w),
      .wr_data_i  (wr_data_i),
      .st_o       (st)
   );

   preg_merge_detect #(
      .LEGACY_STALL   (LEGACY_STALL),
      .HI_EXTRA_STALL (HI_EXTRA_STALL),
      .CNT_W          (CNT_W)
   ) u_detect (
      .mode_i   (mode_q),
      .rd_w_i   (rd_w),
      .lo8_p_i  (src_st.lo8_p),
      .lo16_p_i (src_st.lo16_p),
      .hi8_p_i  (src_st.hi8_p),
      .need_o   (need),
      .cost_o   (cost)
   );

   preg_read_fmt u_fmt (
      .src_i   (src_st),
      .rd_w_i  (rd_w),
      .value_o (rd_value)
   );

   preg_stall_ctrl #(
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .accept_i    (accept),
      .need_i      (need),
      .muop_i      (mode_q == M_MERGE_UOP),
      .cost_i      (cost),
      .value_i     (rd_value),
      .ready_o     (in_ready_o),
      .stall_o     (stall_o),
      .rd_valid_o  (rd_valid_o),
      .rd_data_o   (rd_data_o),
      .merge_req_o (merge_req_o)
   );

endmodule

// File: rtl/preg_merge_checker.sv
module preg_merge_checker
   import preg_pkg::*;
#(
   parameter int unsigned LEGACY_STALL   = 5,
   parameter int unsigned HI_EXTRA_STALL = 1
) (
   input logic  clk,
   input logic  rst_n,
   input mode_e mode,
   input logic  in_valid,
   input logic  in_ready,
   input logic  stall,
   input logic  rd_valid,
   input logic  merge_req
);

   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (stall)
         run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
      else
         run_q <= '0;
   end

   AST_LEGACY_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_LEGACY && stall) |-> (run_q < 8'(LEGACY_STALL))); // R6
   AST_LEGACY_STALL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_LEGACY && $fell(stall)) |-> (run_q == 8'(LEGACY_STALL))); // R6
   AST_MUOP_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_MERGE_UOP && stall) |-> (run_q < 8'(HI_EXTRA_STALL))); // R8
   AST_DIRECT_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_DIRECT) |-> (!stall && !merge_req)); // R9
   AST_MERGE_ONLY_MUOP: assert property (@(posedge clk) disable iff (!rst_n)
      merge_req |-> (mode == M_MERGE_UOP)); // R7
   AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (rd_valid || stall)); // R11
   AST_RESULT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> in_ready); // R11
   AST_STALL_END_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> rd_valid); // R11

endmodule

bind preg_merge_top preg_merge_checker #(
   .LEGACY_STALL   (LEGACY_STALL),
   .HI_EXTRA_STALL (HI_EXTRA_STALL)
) chk_i (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .mode      (mode_q),
   .in_valid  (in_valid_i),
   .in_ready  (in_ready_o),
   .stall     (stall_o),
   .rd_valid  (rd_valid_o),
   .merge_req (merge_req_o)
);

// File: tb/preg_merge_top_tb.sv
module preg_merge_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LSTALL     = 6;
   localparam int HSTALL     = 1;

   typedef struct {
      logic [63:0] data;
      int          cost;
      bit          merge;
      string       tag;
   } exp_t;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic        in_valid_i = 1'b0;
   logic [2:0]  dst_idx_i = '0;
   logic [2:0]  dst_w_i = '0;
   logic [2:0]  src_idx_i = '0;
   logic [2:0]  src_w_i = '0;
   logic [63:0] wr_data_i = '0;
   logic        in_ready_o;
   logic        stall_o;
   logic        merge_req_o;
   logic        rd_valid_o;
   logic [63:0] rd_data_o;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   // reference model
   logic [63:0] m_val [8];
   bit          m_lo8 [8];
   bit          m_lo16 [8];
   bit          m_hi8 [8];
   int          m_mode;

   always #(CLK_PERIOD / 2) clk_i = ~clk_i;

   preg_merge_top #(
      .NREGS          (8),
      .LEGACY_STALL   (LSTALL),
      .HI_EXTRA_STALL (HSTALL)
   ) dut_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode_i),
      .in_valid_i  (in_valid_i),
      .dst_idx_i   (dst_idx_i),
      .dst_w_i     (dst_w_i),
      .src_idx_i   (src_idx_i),
      .src_w_i     (src_w_i),
      .wr_data_i   (wr_data_i),
      .in_ready_o  (in_ready_o),
      .stall_o     (stall_o),
      .merge_req_o (merge_req_o),
      .rd_valid_o  (rd_valid_o),
      .rd_data_o   (rd_data_o)
   );

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   function automatic logic [63:0] model_read(int r, int w);
      logic [63:0] v;
      v = m_val[r];
      case (w)
         0:       return {56'b0, v[7:0]};
         1:       return {56'b0, v[15:8]};
         2:       return {48'b0, v[15:0]};
         3:       return {32'b0, v[31:0]};
         default: return v;
      endcase
   endfunction

   task automatic do_reset(logic [1:0] m);
      while (q.size() != 0 || !in_ready_o) @(posedge clk_i);
      #1;
      rst_ni = 1'b0;
      mode_i = m;
      repeat (3) @(posedge clk_i);
      #1;
      rst_ni = 1'b1;
      m_mode = (m == 2'd3) ? 2 : int'(m);
      for (int r = 0; r < 8; r++) begin
         m_val[r] = '0; m_lo8[r] = 0; m_lo16[r] = 0; m_hi8[r] = 0;
      end
   endtask

   task automatic issue(int dst, int dw, int src, int sw, logic [63:0] d, string tag);
      exp_t e;
      bit   need;
      bit   bytep;
      while (!in_ready_o) begin
         @(posedge clk_i);
         #1;
      end
      // read side, before the write
      bytep = m_lo8[src] || m_hi8[src];
      need  = (m_mode != 2) && ((sw == 2 && bytep) || (sw >= 3 && (bytep || m_lo16[src])));
      e.data  = model_read(src, sw);
      e.merge = (m_mode == 1) && need;
      e.cost  = !need ? 0 : (m_mode == 0) ? LSTALL : (m_hi8[src] ? HSTALL : 0);
      e.tag   = tag;
      if (need) begin
         m_lo8[src] = 0; m_lo16[src] = 0; m_hi8[src] = 0;
      end
      // write side
      case (dw)
         0: begin
            m_val[dst][7:0] = d[7:0];
            if (m_mode != 2 && !m_lo16[dst]) m_lo8[dst] = 1;
         end
         1: begin
            m_val[dst][15:8] = d[7:0];
            if (m_mode != 2) m_hi8[dst] = 1;
         end
         2: begin
            m_val[dst][15:0] = d[15:0];
            if (m_mode != 2) begin
               m_lo16[dst] = 1; m_lo8[dst] = 0; m_hi8[dst] = 0;
            end
         end
         3: begin
            m_val[dst] = {32'b0, d[31:0]};
            m_lo8[dst] = 0; m_lo16[dst] = 0; m_hi8[dst] = 0;
         end
         default: begin
            m_val[dst] = d;
            m_lo8[dst] = 0; m_lo16[dst] = 0; m_hi8[dst] = 0;
         end
      endcase
      q.push_back(e);
      in_valid_i = 1'b1;
      dst_idx_i  = 3'(dst);
      dst_w_i    = 3'(dw);
      src_idx_i  = 3'(src);
      src_w_i    = 3'(sw);
      wr_data_i  = d;
      @(posedge clk_i);
      #1;
      in_valid_i = 1'b0;
   endtask

   // presents an instruction while ready is low; it must be dropped
   task automatic ignored_write(int dst, logic [63:0] d);
      check(in_ready_o == 1'b0, "R11", "ready low during stall", 64'(in_ready_o), 64'd0);
      in_valid_i = 1'b1;
      dst_idx_i  = 3'(dst);
      dst_w_i    = 3'd4;
      src_idx_i  = 3'(dst);
      src_w_i    = 3'd4;
      wr_data_i  = d;
      @(posedge clk_i);
      #1;
      in_valid_i = 1'b0;
   endtask

   // scoreboard monitor
   bit mchk = 0;
   int busy = 0;
   always @(negedge clk_i) begin
      if (!rst_ni) begin
         mchk = 0;
         busy = 0;
      end else begin
         if (!in_ready_o) busy++;
         if (mchk) begin
            if (q.size() != 0)
               check(merge_req_o == q[0].merge, "R7", "merge request", 64'(merge_req_o), 64'(q[0].merge));
            mchk = 0;
         end
         if (rd_valid_o) begin
            if (q.size() == 0) begin
               check(1'b0, "R11", "unexpected result", rd_data_o, 64'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(rd_data_o == e.data, e.tag, "read data", rd_data_o, e.data);
               check(busy == e.cost, e.tag, "stall cycles", 64'(busy), 64'(e.cost));
            end
         end
         if (in_valid_i && in_ready_o) begin
            mchk = 1;
            busy = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      check(1'b0, "WATCHDOG", "run timed out", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      // ---------------- stalling policy ----------------
      do_reset(2'd0);
      @(negedge clk_i);
      check(in_ready_o == 1'b1, "R1", "ready after reset", 64'(in_ready_o), 64'd1);
      check(rd_valid_o == 1'b0, "R1", "valid after reset", 64'(rd_valid_o), 64'd0);
      check(stall_o == 1'b0, "R1", "stall after reset", 64'(stall_o), 64'd0);
      check(merge_req_o == 1'b0, "R1", "merge after reset", 64'(merge_req_o), 64'd0);
      @(posedge clk_i); #1;
      for (int r = 0; r < 7; r++) issue(7, 4, r, 4, 64'd0, "R1");
      issue(0, 4, 7, 4, 64'd0, "R1");

      issue(1, 4, 0, 4, 64'h1122_3344_5566_7788, "R3");
      issue(1, 0, 1, 4, 64'h0000_0000_0000_00AA, "R3");   // read sees old value
      issue(2, 4, 1, 0, 64'd0, "R5");                     // byte read over byte piece
      issue(2, 4, 1, 1, 64'd0, "R2");                     // high-byte read
      issue(2, 4, 1, 4, 64'd0, "R6");                     // wide read stalls
      ignored_write(1, 64'hDEAD_BEEF_DEAD_BEEF);
      issue(2, 4, 1, 4, 64'd0, "R12");                    // already folded
      issue(1, 1, 2, 4, 64'h0000_0000_0000_00CC, "R3");
      issue(2, 4, 1, 2, 64'd0, "R5");                     // word read over high byte
      issue(1, 2, 2, 4, 64'h0000_0000_0000_BEEF, "R3");
      issue(2, 4, 1, 2, 64'd0, "R5");                     // word read over word piece
      issue(2, 4, 1, 3, 64'd0, "R5");                     // 32-bit read over word piece
      issue(3, 4, 2, 4, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      issue(3, 0, 2, 4, 64'h0000_0000_0000_0011, "R3");
      issue(3, 3, 2, 4, 64'h0000_0000_8765_4321, "R4");   // drops the byte piece
      issue(4, 4, 3, 4, 64'd0, "R4");                     // zero upper, no stall
      issue(3, 0, 4, 4, 64'h0000_0000_0000_0022, "R3");
      issue(3, 4, 4, 4, 64'h0123_4567_89AB_CDEF, "R4");
      issue(4, 4, 3, 4, 64'd0, "R4");
      for (int i = 0; i < 60; i++)
         issue(int'($urandom % 8), int'($urandom % 5), int'($urandom % 8), int'($urandom % 5),
               {$urandom, $urandom}, "R6");

      // ---------------- merge-op policy ----------------
      do_reset(2'd1);
      @(posedge clk_i); #1;
      mode_i = 2'd0;                                      // must have no effect
      issue(3, 0, 3, 4, 64'h0000_0000_0000_0055, "R7");
      issue(4, 4, 3, 4, 64'd0, "R7");                     // no stall, merge pulse
      issue(3, 1, 4, 4, 64'h0000_0000_0000_0066, "R10");
      issue(4, 4, 3, 3, 64'd0, "R8");                     // high piece: extra stall
      issue(3, 2, 4, 4, 64'h0000_0000_0000_1234, "R7");
      issue(3, 1, 4, 4, 64'h0000_0000_0000_0077, "R8");
      issue(4, 4, 3, 2, 64'd0, "R8");
      issue(4, 4, 3, 2, 64'd0, "R12");
      for (int i = 0; i < 120; i++)
         issue(int'($urandom % 8), int'($urandom % 5), int'($urandom % 8), int'($urandom % 5),
               {$urandom, $urandom}, "R8");

      // ---------------- direct policy ----------------
      do_reset(2'd3);
      @(posedge clk_i); #1;
      issue(5, 4, 5, 4, 64'hA5A5_A5A5_A5A5_A5A5, "R9");
      issue(5, 0, 5, 4, 64'h0000_0000_0000_0001, "R9");
      issue(6, 4, 5, 4, 64'd0, "R9");                     // no stall, no merge
      issue(5, 1, 5, 3, 64'h0000_0000_0000_0002, "R9");
      issue(6, 4, 5, 2, 64'd0, "R9");
      for (int i = 0; i < 120; i++)
         issue(int'($urandom % 8), int'($urandom % 5), int'($urandom % 8), int'($urandom % 5),
               {$urandom, $urandom}, "R9");

      while (q.size() != 0 || !in_ready_o) @(posedge clk_i);
      repeat (3) @(posedge clk_i);
      finish_run();
   end

endmodule